// File: doc/BRIEF.md
# Heartbeat and Fault-Tone Supervisor

This block watches a stream of pulse events recovered from a daisy-chain link and groups them into bursts. A burst closes after a quiet stretch longer than twice the nominal pulse spacing. The block then sorts it by pulse count: short bursts are dropped, mid-length bursts are heartbeats, and long bursts are fault tones. A millisecond time base drives a supervision timer. The timer raises one sticky flag when heartbeats stop arriving and another when a heartbeat follows its predecessor too closely. A third sticky flag records any received fault tone. One clear input resets all three flags.

A transmit section works independently of the receive side. While enabled, it emits heartbeat bursts at the heartbeat period. When a fault is pending, it emits longer fault-tone bursts at the shorter fault period instead. Each pulse is generated with a programmable high time and pulse spacing in clock cycles.

Top module: `hb_tone_supervisor`

## Requirements
- R1: After reset all three flags and the transmit line are low.
- R2: A burst ends only after more than 2*PULSE_SP_CYC consecutive clock cycles without a pulse event. Pulses separated by 2*PULSE_SP_CYC idle cycles or fewer belong to the same burst. The pulse count restarts from zero for the next burst.
- R3: A burst of fewer than HB_DET pulses is discarded. It sets no flag and does not restart the heartbeat timer.
- R4: A burst of at least HB_DET and fewer than FT_DET pulses is a valid heartbeat. It restarts the heartbeat timer at zero.
- R5: A burst of FT_DET or more pulses sets the fault-tone flag. It is not treated as a heartbeat and leaves the heartbeat timer running.
- R6: The too-fast flag is set when a valid heartbeat ends with fewer than FAST_MS millisecond ticks since the previous valid heartbeat. The first heartbeat after reset is never too fast.
- R7: The missing flag is set on the MISS_MS-th millisecond tick after reset or after the last valid heartbeat. The timer then saturates, so further ticks do not set the flag again until a heartbeat arrives.
- R8: All three flags stay set until the clear input is high for a cycle. If a set condition and the clear occur in the same cycle, the flag ends up set.
- R9: With transmit enabled and no fault pending, a burst of HB_TX pulses starts on the HB_PER_MS-th tick after enable or after the previous burst start.
- R10: With a fault pending when a burst is due, the burst carries FT_TX pulses and the period becomes FT_PER_MS ticks. The burst kind is fixed when the burst starts, so changing the pending input mid-burst has no effect.
- R11: Each transmitted pulse is high for PULSE_HI_CYC cycles. Successive rising edges within a burst are PULSE_SP_CYC cycles apart.
- R12: While transmit is disabled, no burst starts and the period count returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_evt | input | 1 | One-cycle strobe per qualified received pulse |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| flag_clr | input | 1 | Clears all three sticky flags |
| tx_en | input | 1 | Enables periodic burst transmission |
| fault_pend | input | 1 | Selects fault tones instead of heartbeats |
| hb_missing | output | 1 | Sticky: heartbeat absent for MISS_MS ticks |
| hb_fast | output | 1 | Sticky: heartbeat spacing below FAST_MS ticks |
| ftone_rcvd | output | 1 | Sticky: fault-tone burst received |
| tx_pulse | output | 1 | Transmitted pulse line |

## Verification
The bench builds the block with a pulse spacing of 4 cycles and one-cycle pulses. Thresholds are 3 pulses for a heartbeat and 6 for a fault tone, with transmitted bursts of 4 and 8 pulses. The periods are 5 and 3 ticks, the too-fast window is 2 ticks and the missing window is 10 ticks. These small values put every pulse count from zero past the fault threshold within reach of a full sweep. They also allow every heartbeat spacing around the too-fast boundary, the exact tick on which the missing flag rises, and the one-cycle boundary between merged and split bursts. Transmit periods and burst lengths can then be counted edge by edge.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_BEAT  = 2'd1,
    BK_FAULT = 2'd2
  } burst_kind_e;
endpackage

// File: rtl/hbt_burst_rx.sv
module hbt_burst_rx
  import hbt_pkg::*;
#(
  parameter int GAP_LIM = 8,
  parameter int HB_DET  = 20,
  parameter int FT_DET  = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pulse_evt,
  output logic        cls_stb,
  output burst_kind_e cls_kind
);
  localparam int GW = $clog2(GAP_LIM + 1);
  localparam int CW = $clog2(FT_DET + 1);
  localparam logic [GW-1:0] GAP_L = GW'(GAP_LIM);
  localparam logic [CW-1:0] HB_L  = CW'(HB_DET);
  localparam logic [CW-1:0] FT_L  = CW'(FT_DET);

  logic          active_q, active_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          end_w;
  burst_kind_e   kind_w;

  assign end_w = active_q && !pulse_evt && (gap_q == GAP_L);

  always_comb begin
    kind_w = BK_NONE;
    if (cnt_q >= FT_L)      kind_w = BK_FAULT;
    else if (cnt_q >= HB_L) kind_w = BK_BEAT;
  end

  assign cls_stb  = end_w && (kind_w != BK_NONE);
  assign cls_kind = end_w ? kind_w : BK_NONE;

  always_comb begin
    active_d = active_q;
    gap_d    = gap_q;
    cnt_d    = cnt_q;
    if (pulse_evt) begin
      active_d = 1'b1;
      gap_d    = '0;
      cnt_d    = (cnt_q == FT_L) ? cnt_q : cnt_q + 1'b1;
    end else if (end_w) begin
      active_d = 1'b0;
      gap_d    = '0;
      cnt_d    = '0;
    end else if (active_q) begin
      gap_d    = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      gap_q    <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      gap_q    <= gap_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    end_w |=> (cnt_q == '0)); // R2
  AST_CNT_HOLD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !pulse_evt && !end_w) |=> $stable(cnt_q)); // R2
  AST_END_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cls_stb |-> !pulse_evt && active_q); // R3
endmodule

// File: rtl/hbt_beat_mon.sv
module hbt_beat_mon
  import hbt_pkg::*;
#(
  parameter int FAST_MS = 200,
  parameter int MISS_MS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ms_tick,
  input  logic        cls_stb,
  input  burst_kind_e cls_kind,
  input  logic        flag_clr,
  output logic        hb_missing,
  output logic        hb_fast,
  output logic        ftone_rcvd
);
  localparam int MW = $clog2(MISS_MS + 1);
  localparam logic [MW-1:0] MISS_L = MW'(MISS_MS);
  localparam logic [MW-1:0] FAST_L = MW'(FAST_MS);

  logic [MW-1:0] ms_q, ms_d;
  logic prev_q, prev_d;
  logic miss_q, miss_d, fast_q, fast_d, ft_q, ft_d;
  logic beat_w, fault_w, miss_set, fast_set;

  assign beat_w  = cls_stb && (cls_kind == BK_BEAT);
  assign fault_w = cls_stb && (cls_kind == BK_FAULT);

  always_comb begin
    ms_d = ms_q;
    if (beat_w) ms_d = '0;
    else if (ms_tick && (ms_q < MISS_L)) ms_d = ms_q + 1'b1;
  end

  assign miss_set = !beat_w && ms_tick && (ms_q == MISS_L - 1'b1);
  assign fast_set = beat_w && prev_q && (ms_q < FAST_L);

  always_comb begin
    prev_d = prev_q | beat_w;
    miss_d = miss_set | (miss_q & ~flag_clr);
    fast_d = fast_set | (fast_q & ~flag_clr);
    ft_d   = fault_w  | (ft_q   & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q   <= '0;
      prev_q <= 1'b0;
      miss_q <= 1'b0;
      fast_q <= 1'b0;
      ft_q   <= 1'b0;
    end else begin
      ms_q   <= ms_d;
      prev_q <= prev_d;
      miss_q <= miss_d;
      fast_q <= fast_d;
      ft_q   <= ft_d;
    end
  end

  assign hb_missing = miss_q;
  assign hb_fast    = fast_q;
  assign ftone_rcvd = ft_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q && !flag_clr) |=> fast_q); // R8
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cls_stb && !ms_tick) |=> !(miss_q || fast_q || ft_q)); // R8
  AST_MISS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_q) |-> $past(ms_tick)); // R7
  AST_FAST_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_q) |-> $past(beat_w)); // R6
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MISS_L); // R7
endmodule

// File: rtl/hbt_burst_tx.sv
module hbt_burst_tx #(
  parameter int HB_TX        = 30,
  parameter int FT_TX        = 90,
  parameter int HB_PER_MS    = 400,
  parameter int FT_PER_MS    = 50,
  parameter int PULSE_SP_CYC = 460,
  parameter int PULSE_HI_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic tx_en,
  input  logic fault_pend,
  output logic tx_pulse
);
  localparam int PMAX = (HB_PER_MS > FT_PER_MS) ? HB_PER_MS : FT_PER_MS;
  localparam int NMAX = (HB_TX > FT_TX) ? HB_TX : FT_TX;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int RW   = $clog2(NMAX + 1);
  localparam int HW   = $clog2(PULSE_SP_CYC + 1);
  localparam logic [PW-1:0] HB_LIM = PW'(HB_PER_MS - 1);
  localparam logic [PW-1:0] FT_LIM = PW'(FT_PER_MS - 1);
  localparam logic [PW-1:0] P_TOP  = PW'(PMAX - 1);
  localparam logic [RW-1:0] HB_N   = RW'(HB_TX);
  localparam logic [RW-1:0] FT_N   = RW'(FT_TX);
  localparam logic [HW-1:0] SP_END = HW'(PULSE_SP_CYC - 1);
  localparam logic [HW-1:0] HI_L   = HW'(PULSE_HI_CYC);

  logic [PW-1:0] pc_q, pc_d;
  logic          busy_q, busy_d;
  logic [RW-1:0] rem_q, rem_d;
  logic [HW-1:0] ph_q, ph_d;
  logic [PW-1:0] lim_w;
  logic          start_w;

  assign lim_w   = fault_pend ? FT_LIM : HB_LIM;
  assign start_w = tx_en && ms_tick && !busy_q && (pc_q >= lim_w);

  always_comb begin
    pc_d = pc_q;
    if (!tx_en)                pc_d = '0;
    else if (ms_tick) begin
      if (start_w)             pc_d = '0;
      else if (pc_q < P_TOP)   pc_d = pc_q + 1'b1;
    end
  end

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    ph_d   = ph_q;
    if (start_w) begin
      busy_d = 1'b1;
      rem_d  = fault_pend ? FT_N : HB_N;
      ph_d   = '0;
    end else if (busy_q) begin
      if (ph_q == SP_END) begin
        ph_d = '0;
        if (rem_q == RW'(1)) begin
          busy_d = 1'b0;
          rem_d  = '0;
        end else begin
          rem_d  = rem_q - 1'b1;
        end
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
      rem_q  <= '0;
      ph_q   <= '0;
    end else begin
      pc_q   <= pc_d;
      busy_q <= busy_d;
      rem_q  <= rem_d;
      ph_q   <= ph_d;
    end
  end

  assign tx_pulse = busy_q && (ph_q < HI_L);

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ((rem_q == HB_N) || (rem_q == FT_N))); // R10
  AST_TX_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(tx_en) && $past(ms_tick))); // R12
  AST_TX_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0)); // R9
  AST_TX_PERIOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (pc_q == '0)); // R12
endmodule

// File: rtl/hb_tone_supervisor.sv
module hb_tone_supervisor
  import hbt_pkg::*;
#(
  parameter int PULSE_SP_CYC = 460,
  parameter int PULSE_HI_CYC = 40,
  parameter int HB_DET       = 20,
  parameter int FT_DET       = 60,
  parameter int HB_TX        = 30,
  parameter int FT_TX        = 90,
  parameter int HB_PER_MS    = 400,
  parameter int FT_PER_MS    = 50,
  parameter int FAST_MS      = 200,
  parameter int MISS_MS      = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_evt,
  input  logic ms_tick,
  input  logic flag_clr,
  input  logic tx_en,
  input  logic fault_pend,
  output logic hb_missing,
  output logic hb_fast,
  output logic ftone_rcvd,
  output logic tx_pulse
);
  localparam int GAP_LIM = 2 * PULSE_SP_CYC;

  logic        cls_stb;
  burst_kind_e cls_kind;

  hbt_burst_rx #(
    .GAP_LIM (GAP_LIM),
    .HB_DET  (HB_DET),
    .FT_DET  (FT_DET)
  ) i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_evt (pulse_evt),
    .cls_stb   (cls_stb),
    .cls_kind  (cls_kind)
  );

  hbt_beat_mon #(
    .FAST_MS (FAST_MS),
    .MISS_MS (MISS_MS)
  ) i_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .cls_stb    (cls_stb),
    .cls_kind   (cls_kind),
    .flag_clr   (flag_clr),
    .hb_missing (hb_missing),
    .hb_fast    (hb_fast),
    .ftone_rcvd (ftone_rcvd)
  );

  hbt_burst_tx #(
    .HB_TX        (HB_TX),
    .FT_TX        (FT_TX),
    .HB_PER_MS    (HB_PER_MS),
    .FT_PER_MS    (FT_PER_MS),
    .PULSE_SP_CYC (PULSE_SP_CYC),
    .PULSE_HI_CYC (PULSE_HI_CYC)
  ) i_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .tx_en      (tx_en),
    .fault_pend (fault_pend),
    .tx_pulse   (tx_pulse)
  );

  AST_FLAGS_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !(hb_missing || hb_fast || ftone_rcvd || tx_pulse)); // R1
endmodule

// File: tb/test_hb_tone_supervisor.sv
module test_hb_tone_supervisor;
  localparam int SP   = 4;
  localparam int HI   = 1;
  localparam int HBD  = 3;
  localparam int FTD  = 6;
  localparam int HBT  = 4;
  localparam int FTT  = 8;
  localparam int HBP  = 5;
  localparam int FTP  = 3;
  localparam int FAST = 2;
  localparam int MISS = 10;
  localparam int GAP  = 2 * SP;

  logic clk = 1'b0;
  logic rst_n, pulse_evt, ms_tick, flag_clr, tx_en, fault_pend;
  logic hb_missing, hb_fast, ftone_rcvd, tx_pulse;

  always #10 clk = ~clk;

  hb_tone_supervisor #(
    .PULSE_SP_CYC(SP), .PULSE_HI_CYC(HI), .HB_DET(HBD), .FT_DET(FTD),
    .HB_TX(HBT), .FT_TX(FTT), .HB_PER_MS(HBP), .FT_PER_MS(FTP),
    .FAST_MS(FAST), .MISS_MS(MISS)
  ) i_hb_tone_supervisor (
    .clk(clk), .rst_n(rst_n), .pulse_evt(pulse_evt), .ms_tick(ms_tick),
    .flag_clr(flag_clr), .tx_en(tx_en), .fault_pend(fault_pend),
    .hb_missing(hb_missing), .hb_fast(hb_fast), .ftone_rcvd(ftone_rcvd),
    .tx_pulse(tx_pulse)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int  m_ms = 0;
  bit  m_prev = 0, m_miss = 0, m_fast = 0, m_ft = 0;

  int  edges = 0, bad_shape = 0, hi_run = 0, cyc_n = 0, last_rise = -1000;
  logic tx_prev = 1'b0;

  always @(negedge clk) begin
    cyc_n <= cyc_n + 1;
    tx_prev <= tx_pulse;
    if (tx_pulse) begin
      hi_run <= hi_run + 1;
      if (!tx_prev) begin
        edges <= edges + 1;
        if ((cyc_n - last_rise) < 2 * SP && (cyc_n - last_rise) != SP)
          bad_shape <= bad_shape + 1;
        last_rise <= cyc_n;
      end
    end else begin
      if (tx_prev && hi_run != HI) bad_shape <= bad_shape + 1;
      hi_run <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " missing"}, int'(hb_missing), int'(m_miss));
    chk({req, " fast"},    int'(hb_fast),    int'(m_fast));
    chk({req, " ftone"},   int'(ftone_rcvd), int'(m_ft));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_tick();
    if (m_ms < MISS) begin
      m_ms++;
      if (m_ms == MISS) m_miss = 1;
    end
  endtask

  task automatic model_burst(input int n);
    if (n >= FTD) m_ft = 1;
    else if (n >= HBD) begin
      if (m_prev && m_ms < FAST) m_fast = 1;
      m_prev = 1;
      m_ms = 0;
    end
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    model_tick();
    cyc(19);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    m_miss = 0; m_fast = 0; m_ft = 0;
  endtask

  task automatic one_pulse();
    pulse_evt = 1'b1;
    @(negedge clk);
    pulse_evt = 1'b0;
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      one_pulse();
      cyc(SP - 1);
    end
    cyc(GAP + 4);
    model_burst(n);
  endtask

  task automatic split(input int a, input int b, input int idle);
    for (int i = 0; i < a; i++) begin
      one_pulse();
      if (i < a - 1) cyc(SP - 1);
    end
    cyc(idle);
    for (int i = 0; i < b; i++) begin
      one_pulse();
      cyc(SP - 1);
    end
    cyc(GAP + 4);
    if (idle <= GAP) model_burst(a + b);
    else begin
      model_burst(a);
      model_burst(b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pulse_evt = 1'b0; ms_tick = 1'b0; flag_clr = 1'b0;
    tx_en = 1'b0; fault_pend = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk_flags("R1");
    chk("R1 tx", int'(tx_pulse), 0);

    // R7 missing flag rises exactly on the MISS-th tick, then saturates
    ticks(MISS - 1);
    chk("R7 before window", int'(hb_missing), 0);
    tick();
    chk("R7 at window", int'(hb_missing), 1);
    clr();
    tick();
    chk("R7 saturated no re-set", int'(hb_missing), 0);
    chk("R8 clear", int'(hb_missing), int'(m_miss));

    // R4 R6 first heartbeat is never too fast
    burst(HBD);
    chk_flags("R4 R6 first beat");

    // R6 sweep of heartbeat spacing around the too-fast window
    for (int d = 0; d <= FAST + 2; d++) begin
      burst(HBD);
      clr();
      ticks(d);
      burst(HBD + 1);
      chk("R6 spacing sweep", int'(hb_fast), (d < FAST) ? 1 : 0);
      chk_flags("R6 model");
    end

    // R8 fast flag sticky across later ticks and bursts
    clr();
    burst(HBD);
    chk("R8 sticky set", int'(hb_fast), 1);
    ticks(FAST);
    burst(1);
    chk("R8 sticky hold", int'(hb_fast), 1);

    // R3 R4 R5 sweep over burst length
    for (int n = 0; n <= FTD + 2; n++) begin
      burst(HBD);
      clr();
      ticks(FAST);
      burst(n);
      chk("R5 ftone by length", int'(ftone_rcvd), (n >= FTD) ? 1 : 0);
      chk("R3 no fast", int'(hb_fast), 0);
      ticks(MISS - FAST);
      chk("R3 R4 R5 timer restart", int'(hb_missing),
          (n >= HBD && n < FTD) ? 0 : 1);
      chk_flags("R3 R4 R5 model");
    end

    // R2 merge boundary: GAP idle cycles merge, GAP+1 split
    burst(HBD);
    clr();
    ticks(FAST);
    split(2, 2, GAP);
    ticks(MISS - FAST);
    chk("R2 merged burst is beat", int'(hb_missing), 0);
    burst(HBD);
    clr();
    ticks(FAST);
    split(2, 2, GAP + 1);
    ticks(MISS - FAST);
    chk("R2 split bursts discarded", int'(hb_missing), 1);
    chk_flags("R2 model");

    // R8 set wins over simultaneous clear
    burst(HBD);
    clr();
    ticks(MISS - 1);
    ms_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0; flag_clr = 1'b0;
    cyc(2);
    chk("R8 set wins", int'(hb_missing), 1);
    m_ms = MISS; m_miss = 1;

    // R9 heartbeat transmission
    tx_en = 1'b1;
    ticks(HBP - 1);
    chk("R9 no early burst", edges, 0);
    tick();
    chk("R9 first burst length", edges, HBT);
    ticks(HBP - 1);
    chk("R9 period hold", edges, HBT);
    tick();
    chk("R9 second burst", edges, 2 * HBT);
    chk("R11 pulse shape", bad_shape, 0);

    // R10 fault tones at the shorter period, kind latched at start
    fault_pend = 1'b1;
    ticks(FTP);
    cyc(20);
    chk("R10 fault burst length", edges, 2 * HBT + FTT);
    ticks(FTP - 1);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    fault_pend = 1'b0;
    cyc(FTT * SP + 8);
    chk("R10 latched kind", edges, 2 * HBT + 2 * FTT);
    chk("R11 pulse shape fault", bad_shape, 0);

    // R12 disabled transmit and period restart
    tx_en = 1'b0;
    ticks(2 * HBP);
    chk("R12 disabled silent", edges, 2 * HBT + 2 * FTT);
    tx_en = 1'b1;
    ticks(HBP - 1);
    chk("R12 period restarted", edges, 2 * HBT + 2 * FTT);
    tick();
    chk("R12 burst after re-enable", edges, 3 * HBT + 2 * FTT);
    tx_en = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule